// File: doc/BRIEF.md
# Steady-State Genetic Reproduction Unit

This block breeds child genes for a steady-state genetic search. A population of 256 genes, each 25 bits wide, lives in an internal synchronous RAM. Each gene is stored together with a 16-bit fitness value. Software fills the population through a load port while the unit is idle, and can read any slot back through a peek port.

A start pulse sets the number of children to produce. For each child, the unit draws two parent slots from an 8-bit pseudo-random sequence and reads both parents. It then mixes them bit by bit under a crossover mask and flips bits under a mutation mask. Both masks fill serially from a 16-bit pseudo-random source that is compared against two programmable rates. The child is presented to an external fitness evaluator. When that evaluator's score returns, a survival step writes the child over a weaker parent. A best-so-far register keeps the highest child score and the gene that earned it.

The control is a state machine with seven states. IDLE accepts loads, peeks and start. PICK_A issues the first parent read. PICK_B captures the first parent and issues the second read. BREED forms the child. AWAIT holds the child until a score arrives. SURVIVE performs replacement and updates the best register. FINISH raises done for one cycle.

The transitions are:
- IDLE to PICK_A on start with a nonzero count.
- IDLE to FINISH on start with a count of zero.
- PICK_A to PICK_B to BREED to AWAIT unconditionally.
- AWAIT to SURVIVE when a score is valid.
- SURVIVE to PICK_A while children remain, otherwise to FINISH.
- FINISH to IDLE.

Top module: `ssga_breeder`

## Requirements
- R1: After reset, busy, done and child_valid are 0 and best_fit is 0. In IDLE, load_en writes load_gene and load_fit into slot load_addr at the clock edge. In IDLE, peek_gene and peek_fit show slot peek_addr one cycle after the address is applied.
- R2: Parent slots come from an 8-bit LFSR. It shifts left and feeds bit0 with the XOR of bits 7, 5, 4 and 3. Its reset value is 0x5A. Parent 1 is the current value. The LFSR then advances, and parent 2 is the next value. The LFSR advances again before the next child. The LFSR never holds 0, so slot 0 is never a parent and is never overwritten.
- R3: A 16-bit LFSR shifts left and feeds bit0 with the XOR of bits 15, 13, 12 and 10. Its reset value is 0xACE1, and it advances on every clock after reset. On each clock, bit0 of the crossover mask receives (value < xo_rate) and bit0 of the mutation mask receives (value < mut_rate). At the same clock, both 25-bit masks shift toward bit 24. Both masks reset to 0.
- R4: Where a crossover mask bit is 1, the child bit comes from parent 1. Where it is 0, the child bit comes from parent 2. A rate of 0 therefore yields parent 2 unchanged.
- R5: Where a mutation mask bit is 1, the crossed-over bit is inverted. Both masks are taken as they stand during the cycle just before child_valid rises.
- R6: child_valid rises three cycles after the cycle in which start is accepted, and again three cycles after each SURVIVE state. child_gene stays stable while child_valid is high. child_valid falls on the edge that accepts fit_valid. fit_valid is ignored whenever child_valid is low.
- R7: In SURVIVE, if parent 1's stored fitness is below the child's, the child and its score replace parent 1. Otherwise, if parent 2's fitness is below the child's, the child replaces parent 2. Otherwise nothing is written, so ties keep the parent.
- R8: best_fit and best_gene clear to 0 when start is accepted. In SURVIVE, they take the child's score and gene only when that score is strictly greater than best_fit.
- R9: start is accepted only in IDLE. After gens children, done is high for one cycle and busy then falls. When gens is 0, done is high in the cycle after start and no child is produced.
- R10: load_en is ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (accepted in IDLE) |
| gens | input | 16 | Number of children in the run |
| xo_rate | input | 16 | Crossover threshold |
| mut_rate | input | 16 | Mutation threshold |
| load_en | input | 1 | Write one population slot (IDLE only) |
| load_addr | input | 8 | Slot to write |
| load_gene | input | 25 | Gene to write |
| load_fit | input | 16 | Fitness to write |
| peek_addr | input | 8 | Slot to read back |
| peek_gene | output | 25 | Gene of the slot read back |
| peek_fit | output | 16 | Fitness of the slot read back |
| child_valid | output | 1 | Child gene awaiting a score |
| child_gene | output | 25 | Current child gene |
| fit_valid | input | 1 | Child score is valid |
| fit_in | input | 16 | Child score |
| best_fit | output | 16 | Highest child score in this run |
| best_gene | output | 25 | Gene holding best_fit |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Breeding is exercised under four pairs of rates.
- Both rates at zero isolate parent 2 and prove the parent order.
- Crossover at full scale isolates parent 1.
- Mutation at full scale exposes the inversion path and the mask timing.
- Mid-range rates mix all three paths, so any slip of the mask by one cycle shows up.

Child scores are chosen relative to the two parents' stored fitness: above both, between them, equal to the weaker one, and below both. This tells apart the parent-1 priority, the parent-2 fallback and the tie rule. A full read-back of the population after each run then exposes any stray write, including loads or scores offered at the wrong time.

// File: rtl/ssga_pkg.sv
package ssga_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PICK_A,
        ST_PICK_B,
        ST_BREED,
        ST_AWAIT,
        ST_SURVIVE,
        ST_FINISH
    } breed_state_e;
endpackage

// File: rtl/ssga_lfsr.sv
module ssga_lfsr #(
    parameter int          W    = 8,
    parameter logic [W-1:0] TAPS = 8'hB8,
    parameter logic [W-1:0] SEED = 8'h5A
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [W-1:0] q
);
    logic fb;

    // Fibonacci form: shift toward the MSB, parity of the tapped bits enters at bit 0.
    assign fb = ^(q & TAPS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= SEED;
        else if (adv)
            q <= {q[W-2:0], fb};
    end
endmodule

// File: rtl/ssga_mask_gen.sv
module ssga_mask_gen #(
    parameter int               GENE_W = 25,
    parameter int               RND_W  = 16,
    parameter logic [RND_W-1:0] TAPS   = 16'hB400,
    parameter logic [RND_W-1:0] SEED   = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RND_W-1:0]  xo_rate,
    input  logic [RND_W-1:0]  mut_rate,
    output logic [GENE_W-1:0] xo_mask,
    output logic [GENE_W-1:0] mut_mask
);
    logic [RND_W-1:0] rnd;
    logic             xo_hit;
    logic             mut_hit;

    ssga_lfsr #(.W(RND_W), .TAPS(TAPS), .SEED(SEED)) u_rnd (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (1'b1),
        .q     (rnd)
    );

    assign xo_hit  = (rnd < xo_rate);
    assign mut_hit = (rnd < mut_rate);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xo_mask  <= '0;
            mut_mask <= '0;
        end else begin
            xo_mask  <= {xo_mask[GENE_W-2:0], xo_hit};
            mut_mask <= {mut_mask[GENE_W-2:0], mut_hit};
        end
    end
endmodule

// File: rtl/ssga_pool_ram.sv
module ssga_pool_ram #(
    parameter int AW = 8,
    parameter int DW = 41
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic [AW-1:0] ra,
    output logic [DW-1:0] rd
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[wa] <= wd;
        rd <= mem[ra];
    end
endmodule

// File: rtl/ssga_breeder.sv
module ssga_breeder
    import ssga_pkg::*;
#(
    parameter int                GENE_W   = 25,
    parameter int                IDX_W    = 8,
    parameter int                FIT_W    = 16,
    parameter int                RND_W    = 16,
    parameter int                CNT_W    = 16,
    parameter logic [IDX_W-1:0]  IDX_TAPS = 8'hB8,
    parameter logic [IDX_W-1:0]  IDX_SEED = 8'h5A,
    parameter logic [RND_W-1:0]  RND_TAPS = 16'hB400,
    parameter logic [RND_W-1:0]  RND_SEED = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  gens,
    input  logic [RND_W-1:0]  xo_rate,
    input  logic [RND_W-1:0]  mut_rate,
    input  logic              load_en,
    input  logic [IDX_W-1:0]  load_addr,
    input  logic [GENE_W-1:0] load_gene,
    input  logic [FIT_W-1:0]  load_fit,
    input  logic [IDX_W-1:0]  peek_addr,
    output logic [GENE_W-1:0] peek_gene,
    output logic [FIT_W-1:0]  peek_fit,
    output logic              child_valid,
    output logic [GENE_W-1:0] child_gene,
    input  logic              fit_valid,
    input  logic [FIT_W-1:0]  fit_in,
    output logic [FIT_W-1:0]  best_fit,
    output logic [GENE_W-1:0] best_gene,
    output logic              busy,
    output logic              done
);
    localparam int WORD_W = GENE_W + FIT_W;

    breed_state_e state_q, state_d;

    logic [IDX_W-1:0]  pick_idx;
    logic              pick_adv;
    logic [GENE_W-1:0] xo_mask, mut_mask;

    logic              ram_we;
    logic [IDX_W-1:0]  ram_wa, ram_ra;
    logic [WORD_W-1:0] ram_wd, ram_rd;
    logic [GENE_W-1:0] rd_gene;
    logic [FIT_W-1:0]  rd_fit;

    logic [IDX_W-1:0]  p1_idx, p2_idx;
    logic [GENE_W-1:0] p1_gene;
    logic [FIT_W-1:0]  p1_fit, p2_fit;
    logic [GENE_W-1:0] child_q, mix;
    logic [FIT_W-1:0]  child_fit;
    logic [CNT_W-1:0]  remain;

    logic              p1_weak, p2_weak;
    logic              surv_we;
    logic [IDX_W-1:0]  surv_addr;
    logic              load_ok;

    ssga_lfsr #(.W(IDX_W), .TAPS(IDX_TAPS), .SEED(IDX_SEED)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (pick_adv),
        .q     (pick_idx)
    );

    ssga_mask_gen #(
        .GENE_W (GENE_W),
        .RND_W  (RND_W),
        .TAPS   (RND_TAPS),
        .SEED   (RND_SEED)
    ) u_masks (
        .clk      (clk),
        .rst_n    (rst_n),
        .xo_rate  (xo_rate),
        .mut_rate (mut_rate),
        .xo_mask  (xo_mask),
        .mut_mask (mut_mask)
    );

    ssga_pool_ram #(.AW(IDX_W), .DW(WORD_W)) u_pool (
        .clk (clk),
        .we  (ram_we),
        .wa  (ram_wa),
        .wd  (ram_wd),
        .ra  (ram_ra),
        .rd  (ram_rd)
    );

    assign rd_gene   = ram_rd[GENE_W-1:0];
    assign rd_fit    = ram_rd[WORD_W-1:GENE_W];
    assign peek_gene = rd_gene;
    assign peek_fit  = rd_fit;

    // Per-bit uniform crossover, then mutation; parent 2 arrives straight from the RAM.
    for (genvar b = 0; b < GENE_W; b++) begin : g_mix
        assign mix[b] = (xo_mask[b] ? p1_gene[b] : rd_gene[b]) ^ mut_mask[b];
    end

    assign p1_weak   = (p1_fit < child_fit);
    assign p2_weak   = (p2_fit < child_fit);
    assign surv_addr = p1_weak ? p1_idx : p2_idx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start)
                    state_d = (gens == '0) ? ST_FINISH : ST_PICK_A;
            end
            ST_PICK_A:  state_d = ST_PICK_B;
            ST_PICK_B:  state_d = ST_BREED;
            ST_BREED:   state_d = ST_AWAIT;
            ST_AWAIT: begin
                if (fit_valid)
                    state_d = ST_SURVIVE;
            end
            ST_SURVIVE: state_d = (remain == CNT_W'(1)) ? ST_FINISH : ST_PICK_A;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State-decoded outputs and RAM port steering
    always_comb begin
        pick_adv    = 1'b0;
        surv_we     = 1'b0;
        load_ok     = 1'b0;
        ram_ra      = peek_addr;
        child_valid = 1'b0;
        busy        = 1'b1;
        done        = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy    = 1'b0;
                load_ok = load_en;
            end
            ST_PICK_A, ST_PICK_B: begin
                pick_adv = 1'b1;
                ram_ra   = pick_idx;
            end
            ST_AWAIT:   child_valid = 1'b1;
            ST_SURVIVE: surv_we     = p1_weak | p2_weak;
            ST_FINISH:  done        = 1'b1;
            default: ;
        endcase
    end

    assign ram_we     = load_ok | surv_we;
    assign ram_wa     = load_ok ? load_addr : surv_addr;
    assign ram_wd     = load_ok ? {load_fit, load_gene} : {child_fit, child_q};
    assign child_gene = child_q;

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p1_idx    <= '0;
            p2_idx    <= '0;
            p1_gene   <= '0;
            p1_fit    <= '0;
            p2_fit    <= '0;
            child_q   <= '0;
            child_fit <= '0;
            remain    <= '0;
            best_fit  <= '0;
            best_gene <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        remain    <= gens;
                        best_fit  <= '0;
                        best_gene <= '0;
                    end
                end
                ST_PICK_A: p1_idx <= pick_idx;
                ST_PICK_B: begin
                    p1_gene <= rd_gene;
                    p1_fit  <= rd_fit;
                    p2_idx  <= pick_idx;
                end
                ST_BREED: begin
                    p2_fit  <= rd_fit;
                    child_q <= mix;
                end
                ST_AWAIT: begin
                    if (fit_valid)
                        child_fit <= fit_in;
                end
                ST_SURVIVE: begin
                    remain <= remain - CNT_W'(1);
                    if (child_fit > best_fit) begin
                        best_fit  <= child_fit;
                        best_gene <= child_q;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ssga_breeder_chk.sv
module ssga_breeder_chk #(
    parameter int GENE_W = 25,
    parameter int IDX_W  = 8,
    parameter int FIT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              child_valid,
    input logic [GENE_W-1:0] child_gene,
    input logic              fit_valid,
    input logic [FIT_W-1:0]  best_fit,
    input logic              surv_we,
    input logic [IDX_W-1:0]  surv_addr,
    input logic [IDX_W-1:0]  pick_idx
);
    // R6: child held until a score is accepted
    assert_child_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (child_valid && !fit_valid) |=> (child_valid && $stable(child_gene)));

    // R6: a child is only offered inside a run
    assert_valid_in_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        child_valid |-> busy);

    // R9: done is a single-cycle pulse that ends the run
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R8: best score never falls during a run
    assert_best_mono_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (best_fit >= $past(best_fit)));

    // R8: accepted start clears the best score
    assert_best_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (best_fit == '0));

    // R2: slot 0 is never the target of a survival write
    assert_no_slot0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        surv_we |-> (surv_addr != '0));

    // R2: the parent index generator never reaches 0
    assert_idx_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pick_idx != '0);
endmodule

bind ssga_breeder ssga_breeder_chk #(
    .GENE_W (GENE_W),
    .IDX_W  (IDX_W),
    .FIT_W  (FIT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .child_valid (child_valid),
    .child_gene  (child_gene),
    .fit_valid   (fit_valid),
    .best_fit    (best_fit),
    .surv_we     (surv_we),
    .surv_addr   (surv_addr),
    .pick_idx    (pick_idx)
);

// File: tb/ssga_breeder_test.sv
module ssga_breeder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] gens = '0;
    logic [15:0] xo_rate = '0;
    logic [15:0] mut_rate = '0;
    logic        load_en = 1'b0;
    logic [7:0]  load_addr = '0;
    logic [24:0] load_gene = '0;
    logic [15:0] load_fit = '0;
    logic [7:0]  peek_addr = '0;
    logic [24:0] peek_gene;
    logic [15:0] peek_fit;
    logic        child_valid;
    logic [24:0] child_gene;
    logic        fit_valid = 1'b0;
    logic [15:0] fit_in = '0;
    logic [15:0] best_fit;
    logic [24:0] best_gene;
    logic        busy;
    logic        done;

    ssga_breeder uut (
        .clk(clk), .rst_n(rst_n), .start(start), .gens(gens),
        .xo_rate(xo_rate), .mut_rate(mut_rate),
        .load_en(load_en), .load_addr(load_addr), .load_gene(load_gene), .load_fit(load_fit),
        .peek_addr(peek_addr), .peek_gene(peek_gene), .peek_fit(peek_fit),
        .child_valid(child_valid), .child_gene(child_gene),
        .fit_valid(fit_valid), .fit_in(fit_in),
        .best_fit(best_fit), .best_gene(best_gene), .busy(busy), .done(done)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // Behavioural reference state
    logic [24:0] mg [256];
    logic [15:0] mf [256];
    logic [7:0]  m_idx = 8'h5A;
    logic [15:0] m_rnd;
    logic [24:0] m_xo, m_mu, prev_xo, prev_mu;
    logic [15:0] m_best;
    logic [24:0] m_bgene;

    function automatic logic [7:0] nxt8(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    function automatic logic [15:0] nxt16(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    // R3 reference: random source and masks, one step per clock
    always @(posedge clk) begin
        if (!rst_n) begin
            m_rnd = 16'hACE1;
            m_xo = '0; m_mu = '0; prev_xo = '0; prev_mu = '0;
        end else begin
            prev_xo = m_xo;
            prev_mu = m_mu;
            m_xo = {m_xo[23:0], (m_rnd < xo_rate)};
            m_mu = {m_mu[23:0], (m_rnd < mut_rate)};
            m_rnd = nxt16(m_rnd);
        end
    end

    task automatic report;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: run hung actual=%0d expected<150000 cycles", cyc);
            report();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sweep(input string tag);
        for (int a = 0; a < 256; a++) begin
            peek_addr = 8'(a);
            @(negedge clk);
            chk(peek_gene == mg[a] && peek_fit == mf[a],
                $sformatf("R7/R10/R2 pool slot %0d after %s", a, tag),
                {23'd0, peek_fit, peek_gene}, {23'd0, mf[a], mg[a]});
        end
    endtask

    task automatic run(input int n, input logic [15:0] xr, input logic [15:0] mr, input string tag);
        logic [7:0]  p1, p2;
        logic [24:0] exp_c, held;
        logic [15:0] lo, hi, cf;
        xo_rate = xr; mut_rate = mr;
        @(negedge clk);
        start = 1'b1; gens = 16'(n);
        m_best = '0; m_bgene = '0;
        @(negedge clk);
        start = 1'b0;
        fit_valid = 1'b1; fit_in = 16'hFFFF;   // R6: offered outside AWAIT, must be ignored
        @(negedge clk);
        fit_valid = 1'b0;
        chk(!child_valid, {"R6 no child before BREED completes ", tag}, child_valid, 0);
        for (int k = 0; k < n; k++) begin
            while (!child_valid) @(negedge clk);
            p1 = m_idx; m_idx = nxt8(m_idx);
            p2 = m_idx; m_idx = nxt8(m_idx);
            exp_c = ((prev_xo & mg[p1]) | (~prev_xo & mg[p2])) ^ prev_mu;
            chk(child_gene == exp_c, $sformatf("R4/R5 child %0d %s", k, tag), child_gene, exp_c);
            held = child_gene;
            if (k == 1) begin   // R10: load while busy
                load_en = 1'b1; load_addr = 8'd7; load_gene = '0; load_fit = 16'hFFFF;
            end
            @(negedge clk);
            load_en = 1'b0;
            chk(child_valid && child_gene == held, $sformatf("R6 child held %0d %s", k, tag),
                {38'd0, child_gene}, {38'd0, held});
            repeat (k % 3) @(negedge clk);
            lo = (mf[p1] < mf[p2]) ? mf[p1] : mf[p2];
            hi = (mf[p1] < mf[p2]) ? mf[p2] : mf[p1];
            case (k % 4)
                0:       cf = (hi == 16'hFFFF) ? hi : hi + 16'd1;
                1:       cf = lo + 16'd1;
                2:       cf = lo;
                default: cf = (lo == 0) ? 16'd0 : lo - 16'd1;
            endcase
            fit_valid = 1'b1; fit_in = cf;
            if (mf[p1] < cf) begin
                mg[p1] = exp_c; mf[p1] = cf;
            end else if (mf[p2] < cf) begin
                mg[p2] = exp_c; mf[p2] = cf;
            end
            if (cf > m_best) begin
                m_best = cf; m_bgene = exp_c;
            end
            @(negedge clk);
            fit_valid = 1'b0;
            chk(!child_valid, $sformatf("R6 child dropped after score %0d %s", k, tag), child_valid, 0);
        end
        while (!done) @(negedge clk);
        chk(done && busy, {"R9 done pulse ", tag}, {done, busy}, 2'b11);
        @(negedge clk);
        chk(!done && !busy, {"R9 idle after done ", tag}, {done, busy}, 2'b00);
        chk(best_fit == m_best && best_gene == m_bgene, {"R8 best register ", tag},
            {23'd0, best_fit, best_gene}, {23'd0, m_best, m_bgene});
        sweep(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !child_valid && best_fit == 0, "R1 reset state",
            {busy, done, child_valid, best_fit}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 256; i++) begin
            logic [7:0] b;
            b = 8'(i);
            mg[i] = {b, b ^ 8'h5C, 8'(b * 8'd3), 1'b1};
            mf[i] = 16'(((i * 29) % 200) * 3);
            load_en = 1'b1; load_addr = b; load_gene = mg[i]; load_fit = mf[i];
            @(negedge clk);
        end
        load_en = 1'b0;
        sweep("R1 load");

        run(8,  16'h0000, 16'h0000, "rates zero (R4 parent 2)");
        run(8,  16'hFFFF, 16'h0000, "full crossover (R4 parent 1)");
        run(8,  16'h0000, 16'hFFFF, "full mutation (R5)");
        run(40, 16'h8000, 16'h0800, "mixed rates (R3)");

        // R9: zero-length run
        @(negedge clk);
        start = 1'b1; gens = 16'd0;
        @(negedge clk);
        start = 1'b0;
        chk(done && !child_valid, "R9 gens zero done next cycle", {done, child_valid}, 2'b10);
        @(negedge clk);
        chk(!done && !busy && best_fit == 0, "R9/R8 gens zero idle and cleared",
            {done, busy, best_fit}, 0);

        report();
        $finish;
    end
endmodule